// File: doc/BRIEF.md
# Quad Serial DAC Controller

This block is the digital front end of a four-channel, 10-bit voltage converter. A host sends 16-bit command words over a three-wire serial port made of a serial clock, a data line and a combined chip-select/load strobe. While the strobe is low, each rising serial-clock edge shifts one bit into a 16-bit shift register. The most significant bit of that register is driven on a serial output, so several controllers can be chained and share one clock and one strobe. When the strobe rises, the word is decoded. Depending on the address nibble, the 10-bit code goes to one channel, to all channels, or to none. The same strobe edge can also put the block to sleep or wake it.

All serial inputs are oversampled in the system clock domain through two-flop synchronisers. The block provides four code registers, a one-cycle update pulse for each written channel, a sleep flag, and enable lines for the output amplifiers and the reference input of the analog part. An asynchronous active-low clear zeroes the shift register and the codes. The power-on reset also returns the block to the awake state.

Top module: `qdac_ctrl`

## Requirements
- R1: While `cs_ld` is high, edges on `sck` leave the shift register, and so `dout`, unchanged. While `cs_ld` is low, each rising `sck` edge shifts `din` in at bit 0.
- R2: A word is sent most significant bit first. Word bits 15:12 are the address, bits 11:2 are the code (bit 11 is the code MSB), and bits 1:0 are ignored.
- R3: Addresses 1, 2, 3 and 4 write the code into channels 0, 1, 2 and 3. The new value appears on `ch_codes` at the third `clk` rising edge after `cs_ld` rises, and not before.
- R4: Address 15 writes the same code into all four channels.
- R5: Addresses 0 and 9 to 13 change no channel register.
- R6: Address 14 sets `sleep`, drives `out_en` and `ref_en` low, ignores the code field and keeps every channel code.
- R7: While asleep, a load to any address other than 14 clears `sleep`. Channels not written by that load keep their codes.
- R8: `dout` is the shift register MSB, so a bit appears on `dout` after 16 rising `sck` edges. Two chained instances therefore take a 32-bit stream, and the first 16 bits end up in the far instance.
- R9: A load after fewer or more than 16 clock edges decodes whatever the shift register holds at that moment.
- R10: While `clr_n` is low, the shift register and all channel codes are zero and `sleep` is kept. `rst_n` low zeroes all of these and also clears `sleep`.
- R11: Each written channel gets exactly one `ch_upd` pulse, one `clk` long, in the cycle its new code appears. A sleep load gives no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| clr_n | input | 1 | Asynchronous active-low clear of the shift register and the codes |
| sck | input | 1 | Serial clock |
| din | input | 1 | Serial data in |
| cs_ld | input | 1 | Chip select while low; a rising edge loads the word |
| dout | output | 1 | Shift register MSB, used for chaining |
| ch_codes | output | NCH x CODE_W | Channel codes; index 0 is the channel at address 1 |
| ch_upd | output | NCH | One-cycle pulse for each written channel |
| sleep | output | 1 | Low-power state flag |
| out_en | output | NCH | Output amplifier enables, low in sleep |
| ref_en | output | 1 | Reference input enable, low in sleep |

## Verification
A single load edge can both wake the block and write a channel, so the sleep-state update and the channel write fall in the same cycle. The bench provokes this by putting the block to sleep and then loading a channel-write address. It then checks three things: `sleep` and the enables recover, only the addressed code changes, and exactly one update pulse appears. A clear applied during sleep is the second collision: the codes must go to zero while the sleep flag survives.

// File: rtl/qdac_pkg.sv
package qdac_pkg;
  localparam int ADDR_W = 4;
  localparam int PAD_W  = 2;
  localparam logic [ADDR_W-1:0] ADR_SLEEP = 4'hE;
  localparam logic [ADDR_W-1:0] ADR_ALL   = 4'hF;
endpackage

// File: rtl/qdac_sync.sv
module qdac_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] stg, stg_nxt;

  always_comb stg_nxt = {stg[STAGES-2:0], d};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg <= {STAGES{RST_VAL}};
    else        stg <= stg_nxt;
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/qdac_shifter.sv
module qdac_shifter #(
  parameter int WORD_W = 16,
  parameter int PAD_W  = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    data_rst_n,
  input  logic                    sck_s,
  input  logic                    din_s,
  input  logic                    csl_s,
  output logic [WORD_W-1:PAD_W]   field,
  output logic                    msb,
  output logic                    load
);
  logic [WORD_W-1:0] sr, sr_nxt;
  logic sck_d, csl_d, shift_en;

  always_comb begin
    shift_en = sck_s & ~sck_d & ~csl_s;
    load     = csl_s & ~csl_d;
    sr_nxt   = {sr[WORD_W-2:0], din_s};
  end

  always_ff @(posedge clk or negedge data_rst_n) begin
    if (!data_rst_n)   sr <= '0;
    else if (shift_en) sr <= sr_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_d <= 1'b0;
      csl_d <= 1'b1;
    end else begin
      sck_d <= sck_s;
      csl_d <= csl_s;
    end
  end

  assign field = sr[WORD_W-1:PAD_W];
  assign msb   = sr[WORD_W-1];
endmodule

// File: rtl/qdac_decode.sv
module qdac_decode
  import qdac_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int CODE_W = 10
) (
  input  logic [ADDR_W+CODE_W-1:0] field,
  input  logic                     load,
  output logic [ADDR_W-1:0]        addr,
  output logic [CODE_W-1:0]        code,
  output logic [NCH-1:0]           wr_en,
  output logic                     sleep_cmd,
  output logic                     wake_cmd
);
  assign addr      = field[ADDR_W+CODE_W-1 -: ADDR_W];
  assign code      = field[CODE_W-1:0];
  assign sleep_cmd = load & (addr == ADR_SLEEP);
  assign wake_cmd  = load & (addr != ADR_SLEEP);

  for (genvar i = 0; i < NCH; i++) begin : g_sel
    assign wr_en[i] = load & ((addr == ADDR_W'(i + 1)) | (addr == ADR_ALL));
  end
endmodule

// File: rtl/qdac_ctrl.sv
module qdac_ctrl
  import qdac_pkg::*;
#(
  parameter int NCH         = 4,
  parameter int CODE_W      = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         clr_n,
  input  logic                         sck,
  input  logic                         din,
  input  logic                         cs_ld,
  output logic                         dout,
  output logic [NCH-1:0][CODE_W-1:0]   ch_codes,
  output logic [NCH-1:0]               ch_upd,
  output logic                         sleep,
  output logic [NCH-1:0]               out_en,
  output logic                         ref_en
);
  localparam int WORD_W = ADDR_W + CODE_W + PAD_W;
  localparam int N_IN   = 3;
  localparam logic [N_IN-1:0] SYNC_RST = 3'b100;

  logic                     data_rst_n;
  logic [N_IN-1:0]          raw_in, syn_in;
  logic [WORD_W-1:PAD_W]    field;
  logic                     load, sleep_cmd, wake_cmd;
  logic [ADDR_W-1:0]        addr;
  logic [CODE_W-1:0]        code;
  logic [NCH-1:0]           wr_en;
  logic                     sleep_q, sleep_nxt;

  assign data_rst_n = rst_n & clr_n;
  assign raw_in     = {cs_ld, din, sck};

  for (genvar s = 0; s < N_IN; s++) begin : g_sync
    qdac_sync #(.STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST[s])) u_sync (
      .clk(clk), .rst_n(rst_n), .d(raw_in[s]), .q(syn_in[s]));
  end

  qdac_shifter #(.WORD_W(WORD_W), .PAD_W(PAD_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .data_rst_n(data_rst_n),
    .sck_s(syn_in[0]), .din_s(syn_in[1]), .csl_s(syn_in[2]),
    .field(field), .msb(dout), .load(load));

  qdac_decode #(.NCH(NCH), .CODE_W(CODE_W)) u_dec (
    .field(field), .load(load), .addr(addr), .code(code),
    .wr_en(wr_en), .sleep_cmd(sleep_cmd), .wake_cmd(wake_cmd));

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic [CODE_W-1:0] code_q;
    logic              upd_q;
    always_ff @(posedge clk or negedge data_rst_n) begin
      if (!data_rst_n) begin
        code_q <= '0;
        upd_q  <= 1'b0;
      end else begin
        upd_q <= wr_en[i];
        if (wr_en[i]) code_q <= code;
      end
    end
    assign ch_codes[i] = code_q;
    assign ch_upd[i]   = upd_q;
  end

  always_comb begin
    sleep_nxt = sleep_q;
    if (sleep_cmd)     sleep_nxt = 1'b1;
    else if (wake_cmd) sleep_nxt = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sleep_q <= 1'b0;
    else        sleep_q <= sleep_nxt;
  end

  assign sleep  = sleep_q;
  assign out_en = {NCH{~sleep_q}};
  assign ref_en = ~sleep_q;
endmodule

// File: rtl/qdac_ctrl_chk.sv
module qdac_ctrl_chk #(
  parameter int NCH    = 4,
  parameter int CODE_W = 10
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       clr_n,
  input logic                       load,
  input logic [3:0]                 addr,
  input logic                       csl_s,
  input logic                       dout,
  input logic                       sleep,
  input logic [NCH-1:0][CODE_W-1:0] ch_codes,
  input logic [NCH-1:0]             ch_upd
);
  assert_hold_when_deselected_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (csl_s && $past(csl_s) && clr_n && $past(clr_n)) |-> $stable(dout));

  assert_codes_hold_without_update_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && $past(clr_n) && ch_upd == '0) |-> $stable(ch_codes));

  assert_sleep_entry_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (load && addr == 4'hE) |=> (sleep && ch_upd == '0));

  assert_wake_any_other_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (load && addr != 4'hE) |=> !sleep);

  assert_clear_zeroes_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n |-> (ch_codes == '0 && !dout && ch_upd == '0));

  assert_pulse_follows_load_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_upd != '0) |-> $past(load));

  assert_pulse_shape_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(ch_upd) <= 1 || ch_upd == '1));
endmodule

bind qdac_ctrl qdac_ctrl_chk #(.NCH(NCH), .CODE_W(CODE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .load(load), .addr(addr),
  .csl_s(syn_in[2]), .dout(dout), .sleep(sleep), .ch_codes(ch_codes),
  .ch_upd(ch_upd));

// File: tb/tb_qdac_ctrl.sv
module tb_qdac_ctrl;
  logic clk = 1'b0, rst_n = 1'b0, clr_n = 1'b1;
  logic sck = 1'b0, din = 1'b0, cs_ld = 1'b1;
  logic dout, sleep, ref_en, t_dout, t_sleep, t_ref_en;
  logic [3:0][9:0] codes, t_codes;
  logic [3:0] upd, out_en, t_upd, t_out_en;

  always #2.5 clk = ~clk;

  qdac_ctrl dut (.clk(clk), .rst_n(rst_n), .clr_n(clr_n), .sck(sck), .din(din),
    .cs_ld(cs_ld), .dout(dout), .ch_codes(codes), .ch_upd(upd), .sleep(sleep),
    .out_en(out_en), .ref_en(ref_en));

  qdac_ctrl u_tail (.clk(clk), .rst_n(rst_n), .clr_n(clr_n), .sck(sck), .din(dout),
    .cs_ld(cs_ld), .dout(t_dout), .ch_codes(t_codes), .ch_upd(t_upd), .sleep(t_sleep),
    .out_en(t_out_en), .ref_en(t_ref_en));

  int n_chk = 0, n_fail = 0;
  int upd_cnt[4];
  logic [9:0]  m_code[4];
  logic        m_sleep;
  logic [15:0] m_sr;

  always @(posedge clk)
    for (int i = 0; i < 4; i++) if (upd[i]) upd_cnt[i]++;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic shift_bit(input logic b);
    din = b;
    wclk(4); sck = 1'b1;
    wclk(4); sck = 1'b0;
    m_sr = {m_sr[14:0], b};
  endtask

  task automatic model_load();
    logic [3:0] a;
    a = m_sr[15:12];
    if (a == 4'hE) m_sleep = 1'b1;
    else begin
      m_sleep = 1'b0;
      if (a >= 4'h1 && a <= 4'h4) m_code[a-1] = m_sr[11:2];
      if (a == 4'hF) for (int i = 0; i < 4; i++) m_code[i] = m_sr[11:2];
    end
  endtask

  task automatic cs_low();
    wclk(2); cs_ld = 1'b0; wclk(4);
  endtask

  task automatic cs_high();
    wclk(4); cs_ld = 1'b1; wclk(6);
    model_load();
  endtask

  task automatic send_word(input logic [15:0] w);
    for (int i = 0; i < 4; i++) upd_cnt[i] = 0;
    cs_low();
    for (int k = 15; k >= 0; k--) shift_bit(w[k]);
    cs_high();
  endtask

  task automatic check_state(input string tag);
    for (int i = 0; i < 4; i++) chk(codes[i] === m_code[i], tag, codes[i], m_code[i]);
    chk(sleep === m_sleep, {tag, " sleep"}, sleep, m_sleep);
    chk(out_en === {4{~m_sleep}} && ref_en === ~m_sleep, "R6 enables", {out_en, ref_en}, {{4{~m_sleep}}, ~m_sleep});
  endtask

  task automatic check_pulses(input logic [3:0] exp, input string tag);
    for (int i = 0; i < 4; i++) chk(upd_cnt[i] == int'(exp[i]), tag, upd_cnt[i], exp[i]);
  endtask

  task automatic t_reset();
    for (int i = 0; i < 4; i++) m_code[i] = '0;
    m_sleep = 1'b0; m_sr = '0;
    rst_n = 1'b0; wclk(4); rst_n = 1'b1; wclk(4);
    check_state("R10 reset");
    chk(dout === 1'b0, "R10 reset dout", dout, 0);
  endtask

  task automatic t_timed_write();
    cs_low();
    for (int k = 15; k >= 0; k--) shift_bit(k[0] ? 1'b0 : ((16'h1556 >> k) & 1) != 0);
    m_sr = 16'h1556;
    for (int i = 0; i < 4; i++) upd_cnt[i] = 0;
    cs_ld = 1'b1;
    wclk(2);
    chk(codes[0] === 10'h000, "R3 not before third edge", codes[0], 0);
    wclk(1);
    chk(codes[0] === 10'h155, "R3 third edge", codes[0], 10'h155);
    wclk(4);
    model_load();
    check_pulses(4'b0001, "R11 pulse ch0");
  endtask

  task automatic t_channels();
    send_word({4'h2, 10'h2AA, 2'b11}); check_state("R2 ch1 pad ignored");
    check_pulses(4'b0010, "R11 pulse ch1");
    send_word({4'h3, 10'h001, 2'b00}); check_state("R3 ch2");
    send_word({4'h4, 10'h200, 2'b10}); check_state("R2 ch3 msb");
  endtask

  task automatic t_broadcast();
    send_word({4'hF, 10'h0C3, 2'b00}); check_state("R4 broadcast");
    check_pulses(4'b1111, "R11 pulse all");
    send_word({4'h1, 10'h111, 2'b00});
    send_word({4'h3, 10'h333, 2'b00});
  endtask

  task automatic t_nochange();
    logic [3:0] nop[6] = '{4'h0, 4'h9, 4'hA, 4'hB, 4'hC, 4'hD};
    for (int i = 0; i < 6; i++) begin
      send_word({nop[i], 10'h3FF, 2'b00});
      check_state("R5 no-change");
      check_pulses(4'b0000, "R5 no pulse");
    end
  endtask

  task automatic t_sleep_wake();
    send_word({4'hE, 10'h3FF, 2'b00}); check_state("R6 sleep");
    check_pulses(4'b0000, "R11 no pulse on sleep");
    send_word({4'hA, 10'h000, 2'b00}); check_state("R7 wake via no-change");
    send_word({4'hE, 10'h155, 2'b00}); check_state("R6 sleep again");
    send_word({4'h2, 10'h0F0, 2'b00}); check_state("R7 wake with write");
    check_pulses(4'b0010, "R7 R11 single pulse on wake write");
  endtask

  task automatic t_ignore_sck();
    logic d0;
    send_word({4'h1, 10'h05A, 2'b00});
    d0 = dout;
    din = 1'b1;
    for (int i = 0; i < 16; i++) begin wclk(4); sck = 1'b1; wclk(4); sck = 1'b0; end
    wclk(4);
    chk(dout === d0, "R1 dout held while deselected", dout, d0);
    cs_low(); cs_high();
    check_state("R1 register untouched");
  endtask

  task automatic t_partial();
    cs_low();
    for (int k = 4; k >= 0; k--) shift_bit(k[0]);
    cs_high();
    check_state("R9 short word");
    cs_low();
    for (int k = 19; k >= 0; k--) shift_bit((20'hA4F37 >> k) & 1);
    cs_high();
    check_state("R9 long word");
  endtask

  task automatic t_dout_delay();
    logic [15:0] w1 = 16'hB3C5, w2 = 16'h2154;
    cs_low();
    for (int k = 15; k >= 0; k--) shift_bit(w1[k]);
    for (int k = 15; k >= 0; k--) begin
      chk(dout === w1[k], "R8 dout after 16 edges", dout, w1[k]);
      shift_bit(w2[k]);
    end
    cs_high();
    check_state("R8 second word decoded");
  endtask

  task automatic t_chain();
    logic [15:0] wt = {4'h2, 10'h2AB, 2'b00}, wh = {4'h4, 10'h0F0, 2'b11};
    cs_low();
    for (int k = 15; k >= 0; k--) shift_bit(wt[k]);
    for (int k = 15; k >= 0; k--) shift_bit(wh[k]);
    cs_high();
    chk(t_codes[1] === 10'h2AB, "R8 chain far code", t_codes[1], 10'h2AB);
    check_state("R8 chain near");
  endtask

  task automatic t_clear();
    send_word({4'hE, 10'h000, 2'b00});
    clr_n = 1'b0; wclk(3);
    for (int i = 0; i < 4; i++) m_code[i] = '0;
    m_sr = '0;
    check_state("R10 clear keeps sleep");
    chk(dout === 1'b0, "R10 clear dout", dout, 0);
    clr_n = 1'b1; wclk(3);
    send_word({4'h3, 10'h1C7, 2'b00}); check_state("R7 wake after clear");
  endtask

  task automatic t_random();
    for (int n = 0; n < 40; n++) begin
      logic [15:0] w = 16'($urandom);
      send_word(w);
      check_state("R3 random");
    end
  endtask

  task automatic t_reset_sleep();
    send_word({4'hE, 10'h000, 2'b00});
    rst_n = 1'b0; wclk(3);
    for (int i = 0; i < 4; i++) m_code[i] = '0;
    m_sleep = 1'b0; m_sr = '0;
    check_state("R10 reset clears sleep");
    rst_n = 1'b1; wclk(3);
  endtask

  bit done = 1'b0;

  initial begin
    t_reset();
    t_timed_write();
    t_channels();
    t_broadcast();
    t_nochange();
    t_sleep_wake();
    t_ignore_sck();
    t_partial();
    t_dout_delay();
    t_chain();
    t_clear();
    t_random();
    t_reset_sleep();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule